// File: doc/BRIEF.md
# Serial Transmit Queue with Low-Water Flags

This block holds bytes waiting to go out of a serial port. The CPU pushes bytes through a data write strobe. A character-tick input drains one byte per tick and presents it on a registered output for the serialiser. The serialiser itself sits outside this block.

The queue tracks a programmable low-water trigger. When a drain leaves the fill level at or below the trigger, the block raises a "room available" flag and pulses a DMA request. If the transmit interrupt is enabled, it also raises the interrupt line. A separate "all sent" flag marks the moment the queue drains to empty. Software clears these flags by writing the status port. The room flag cannot be cleared while the fill level is still at or below the trigger. The fill level appears in a shared count word next to a receive count that passes through unchanged.

Top module: `txq_lowwater`

## Requirements
- R1: After reset the queue is empty, the all-sent flag (tend_o) and the room flag (tdfe_o) are both 1, txi_o and dma_req_o are 0, and the trigger level is 8.
- R2: An accepted data write appends wr_data_i. A tick with a non-empty queue removes the oldest byte, and that byte appears on tx_data_o with tx_valid_o high for one cycle, in the cycle after the tick edge. A tick on an empty queue produces no output.
- R3: The queue holds 16 bytes. A data write is discarded when the fill level before the edge is 16, even if a tick drains a byte in the same cycle.
- R4: The count word cnt_reg_o carries the fill level in bits 12:8 and rx_cnt_i in bits 3:0. All other bits are 0.
- R5: A control write (fcr_wr_i) loads the trigger selector from fcr_data_i bits 5:4. The codes 00, 01, 10 and 11 select trigger levels of 8, 4, 2 and 1.
- R6: When a tick drain leaves a fill level at or below the trigger, tdfe_o is set and dma_req_o pulses for one cycle. txi_o is also set if tie_i is 1.
- R7: A tick drain that leaves the queue empty sets tend_o.
- R8: A control write with fcr_data_i bit 2 set empties the queue and sets tend_o and tdfe_o. If tie_i is 1, it also sets txi_o and pulses dma_req_o. Any data write or tick in the same cycle is ignored.
- R9: A status write (sts_wr_i) ANDs tend_o with sts_tend_i. It ANDs tdfe_o with sts_tdfe_i only when the fill level is above the trigger; otherwise tdfe_o stays 1. Writing 1 never sets a flag.
- R10: When a status write leaves tdfe_o at 0 while tie_i is 1, txi_o is cleared. A drain in the same cycle takes precedence by R6.
- R11: A data write alone changes none of tend_o, tdfe_o or txi_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Data write strobe |
| wr_data_i | input | 8 | Byte to enqueue |
| tick_i | input | 1 | Character tick, drains one byte |
| fcr_wr_i | input | 1 | Control write strobe |
| fcr_data_i | input | 8 | Control value: bits 5:4 trigger selector, bit 2 queue flush |
| sts_wr_i | input | 1 | Status write strobe |
| sts_tend_i | input | 1 | Status write value for the all-sent flag |
| sts_tdfe_i | input | 1 | Status write value for the room flag |
| tie_i | input | 1 | Transmit interrupt enable |
| rx_cnt_i | input | 4 | Receive count placed in the low field of the count word |
| tx_valid_o | output | 1 | Drained byte valid, one cycle |
| tx_data_o | output | 8 | Drained byte |
| tend_o | output | 1 | All-sent flag |
| tdfe_o | output | 1 | Room (low-water) flag |
| txi_o | output | 1 | Transmit interrupt request |
| dma_req_o | output | 1 | DMA request pulse |
| cnt_reg_o | output | 16 | Shared count word |

## Verification
A corrupted pointer shows up at tx_data_o on the first tick that reads the bad slot. This happens one cycle after that tick, as a byte out of order or a byte that was never written.

A miscounted fill level shows on cnt_reg_o bits 12:8 in the cycle after the edge that caused it. It also shows up later as a room flag or DMA pulse that fires one drain too early or too late.

A flag or interrupt register left in the wrong state is visible directly on tend_o, tdfe_o or txi_o. The bench compares these against a queue-based model on every cycle, so a fault is caught within one clock of its cause.

// File: rtl/txq_lowwater_pkg.sv
package txq_lowwater_pkg;
  localparam int unsigned FCR_TXRST_BIT = 2;
  localparam int unsigned FCR_TRIG_LSB  = 4;

  // trigger levels halve per selector code: top, top/2, top/4, top/8
  function automatic int unsigned trig_level(input logic [1:0] sel, input int unsigned top);
    return top >> sel;
  endfunction
endpackage

// File: rtl/txq_store.sv
module txq_store #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  input  logic              flush_i,
  output logic              pop_fire_o,
  output logic [DATA_W-1:0] head_data_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wp_q, rp_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              push_ok, pop_ok;

  // fullness judged on the pre-edge level
  assign push_ok = push_i && (cnt_q != CNT_W'(DEPTH)) && !flush_i;
  assign pop_ok  = pop_i && (cnt_q != '0) && !flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wp_q <= wp_q + PTR_W'(1);
      if (pop_ok)  rp_q <= rp_q + PTR_W'(1);
      unique case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wp_q] <= push_data_i;
  end

  assign pop_fire_o  = pop_ok;
  assign head_data_o = mem_q[rp_q];
  assign cnt_o       = cnt_q;
endmodule

// File: rtl/txq_flags.sv
module txq_flags #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pop_i,
  input  logic             flush_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] trig_i,
  input  logic             sts_wr_i,
  input  logic             sts_tend_i,
  input  logic             sts_tdfe_i,
  input  logic             tie_i,
  output logic             tend_o,
  output logic             tdfe_o,
  output logic             txi_o,
  output logic             dma_o
);
  logic tend_q, tdfe_q, txi_q, dma_q;
  logic tend_d, tdfe_d, txi_d, dma_d;
  logic [CNT_W-1:0] cnt_left;

  assign cnt_left = cnt_i - CNT_W'(1);

  always_comb begin
    tend_d = tend_q;
    tdfe_d = tdfe_q;
    txi_d  = txi_q;
    dma_d  = 1'b0;
    if (flush_i) begin
      tend_d = 1'b1;
      tdfe_d = 1'b1;
      if (tie_i) begin
        txi_d = 1'b1;
        dma_d = 1'b1;
      end
    end else begin
      if (sts_wr_i) begin
        tend_d = tend_q & sts_tend_i;
        tdfe_d = (cnt_i <= trig_i) ? 1'b1 : (tdfe_q & sts_tdfe_i);
        if (!tdfe_d && tie_i) txi_d = 1'b0;
      end
      // drain events win over a same-cycle status clear
      if (pop_i && (cnt_left <= trig_i)) begin
        tdfe_d = 1'b1;
        dma_d  = 1'b1;
        if (tie_i) txi_d = 1'b1;
        if (cnt_left == '0) tend_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tend_q <= 1'b1;
      tdfe_q <= 1'b1;
      txi_q  <= 1'b0;
      dma_q  <= 1'b0;
    end else begin
      tend_q <= tend_d;
      tdfe_q <= tdfe_d;
      txi_q  <= txi_d;
      dma_q  <= dma_d;
    end
  end

  assign tend_o = tend_q;
  assign tdfe_o = tdfe_q;
  assign txi_o  = txi_q;
  assign dma_o  = dma_q;
endmodule

// File: rtl/txq_lowwater.sv
module txq_lowwater
  import txq_lowwater_pkg::*;
#(
  parameter int unsigned DEPTH    = 16,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned TRIG_TOP = 8,
  parameter int unsigned RX_CNT_W = 4,
  parameter int unsigned CNT_LSB  = 8,
  parameter int unsigned REG_W    = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic                tick_i,
  input  logic                fcr_wr_i,
  input  logic [7:0]          fcr_data_i,
  input  logic                sts_wr_i,
  input  logic                sts_tend_i,
  input  logic                sts_tdfe_i,
  input  logic                tie_i,
  input  logic [RX_CNT_W-1:0] rx_cnt_i,
  output logic                tx_valid_o,
  output logic [DATA_W-1:0]   tx_data_o,
  output logic                tend_o,
  output logic                tdfe_o,
  output logic                txi_o,
  output logic                dma_req_o,
  output logic [REG_W-1:0]    cnt_reg_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1;

  logic              flush;
  logic [1:0]        trig_sel_q;
  logic [CNT_W-1:0]  trig_lvl;
  logic              pop_fire;
  logic [DATA_W-1:0] head_data;
  logic [CNT_W-1:0]  cnt;
  logic              tx_valid_q;
  logic [DATA_W-1:0] tx_data_q;
  logic              unused_fcr;

  assign flush      = fcr_wr_i && fcr_data_i[FCR_TXRST_BIT];
  assign unused_fcr = ^{fcr_data_i[7:6], fcr_data_i[3], fcr_data_i[1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       trig_sel_q <= 2'b00;
    else if (fcr_wr_i) trig_sel_q <= fcr_data_i[FCR_TRIG_LSB +: 2];
  end

  assign trig_lvl = CNT_W'(trig_level(trig_sel_q, TRIG_TOP));

  txq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) store_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (wr_en_i),
    .push_data_i (wr_data_i),
    .pop_i       (tick_i),
    .flush_i     (flush),
    .pop_fire_o  (pop_fire),
    .head_data_o (head_data),
    .cnt_o       (cnt)
  );

  txq_flags #(.CNT_W(CNT_W)) flags_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pop_i      (pop_fire),
    .flush_i    (flush),
    .cnt_i      (cnt),
    .trig_i     (trig_lvl),
    .sts_wr_i   (sts_wr_i),
    .sts_tend_i (sts_tend_i),
    .sts_tdfe_i (sts_tdfe_i),
    .tie_i      (tie_i),
    .tend_o     (tend_o),
    .tdfe_o     (tdfe_o),
    .txi_o      (txi_o),
    .dma_o      (dma_req_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_valid_q <= 1'b0;
      tx_data_q  <= '0;
    end else begin
      tx_valid_q <= pop_fire;
      if (pop_fire) tx_data_q <= head_data;
    end
  end

  assign tx_valid_o = tx_valid_q;
  assign tx_data_o  = tx_data_q;

  always_comb begin
    cnt_reg_o = '0;
    cnt_reg_o[CNT_LSB +: CNT_W]  = cnt;
    cnt_reg_o[RX_CNT_W-1:0]      = rx_cnt_i;
  end
endmodule

// File: rtl/txq_lowwater_chk.sv
module txq_lowwater_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             tick_i,
  input logic             fcr_wr_i,
  input logic             fcr_txrst_i,
  input logic             sts_wr_i,
  input logic             tend_o,
  input logic             tdfe_o,
  input logic             dma_req_o,
  input logic [CNT_W-1:0] cnt_i
);
  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CNT_W'(DEPTH));

  assert_dma_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> $past(tick_i || (fcr_wr_i && fcr_txrst_i)));

  assert_drain_empty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(tick_i && !(fcr_wr_i && fcr_txrst_i) && cnt_i == CNT_W'(1)) |-> (tend_o && tdfe_o));

  assert_flush_state_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(fcr_wr_i && fcr_txrst_i) |-> (cnt_i == '0 && tend_o && tdfe_o));

  assert_write_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_en_i && !tick_i && !sts_wr_i && !fcr_wr_i) |-> ($stable(tend_o) && $stable(tdfe_o)));
endmodule

bind txq_lowwater txq_lowwater_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .tick_i      (tick_i),
  .fcr_wr_i    (fcr_wr_i),
  .fcr_txrst_i (fcr_data_i[txq_lowwater_pkg::FCR_TXRST_BIT]),
  .sts_wr_i    (sts_wr_i),
  .tend_o      (tend_o),
  .tdfe_o      (tdfe_o),
  .dma_req_o   (dma_req_o),
  .cnt_i       (cnt_reg_o[CNT_LSB +: CNT_W])
);

// File: tb/txq_lowwater_tb.sv
`timescale 1ns/1ps
module txq_lowwater_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, tick = 1'b0, fcr_wr = 1'b0, sts_wr = 1'b0;
  logic        sts_tend = 1'b0, sts_tdfe = 1'b0, tie = 1'b0;
  logic [7:0]  wr_data = '0, fcr_data = '0;
  logic [3:0]  rx_cnt = '0;
  logic        tx_valid, tend, tdfe, txi, dma;
  logic [7:0]  tx_data;
  logic [15:0] cnt_reg;

  int    n_chk = 0, n_err = 0;
  bit    done = 1'b0;
  string phase = "R1";

  always #5 clk = ~clk;

  txq_lowwater dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data), .tick_i(tick),
    .fcr_wr_i(fcr_wr), .fcr_data_i(fcr_data), .sts_wr_i(sts_wr), .sts_tend_i(sts_tend),
    .sts_tdfe_i(sts_tdfe), .tie_i(tie), .rx_cnt_i(rx_cnt), .tx_valid_o(tx_valid),
    .tx_data_o(tx_data), .tend_o(tend), .tdfe_o(tdfe), .txi_o(txi), .dma_req_o(dma),
    .cnt_reg_o(cnt_reg)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL [%s] %s act=%0h exp=%0h", phase, what, act, exp);
    end
  endtask

  // behavioural reference
  byte unsigned mq[$];
  bit  m_tend, m_tdfe, m_txi, m_dma, m_valid;
  byte unsigned m_data;
  int  m_trig;

  always @(posedge clk) begin
    int c;
    c = mq.size();
    if (!rst_n) begin
      mq.delete(); m_tend = 1; m_tdfe = 1; m_txi = 0; m_dma = 0; m_valid = 0; m_data = 0; m_trig = 8;
    end else begin
      m_dma = 0; m_valid = 0;
      if (fcr_wr && fcr_data[2]) begin
        mq.delete(); m_tend = 1; m_tdfe = 1;
        if (tie) begin m_txi = 1; m_dma = 1; end
      end else begin
        if (sts_wr) begin
          m_tend = m_tend & sts_tend;
          if (c <= m_trig) m_tdfe = 1; else m_tdfe = m_tdfe & sts_tdfe;
          if (!m_tdfe && tie) m_txi = 0;
        end
        if (tick && c > 0) begin
          m_data = mq.pop_front(); m_valid = 1;
          if (c - 1 <= m_trig) begin
            m_tdfe = 1; m_dma = 1;
            if (tie) m_txi = 1;
            if (c == 1) m_tend = 1;
          end
        end
        if (wr_en && c < 16) mq.push_back(wr_data);
      end
      if (fcr_wr) m_trig = 8 >> fcr_data[5:4];
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("tend R7", tend, m_tend);
      chk("tdfe R6", tdfe, m_tdfe);
      chk("txi R10", txi, m_txi);
      chk("dma R6", dma, m_dma);
      chk("valid R2", tx_valid, m_valid);
      if (m_valid) chk("data R2", tx_data, m_data);
      chk("count R4", cnt_reg, (mq.size() << 8) | rx_cnt);
    end
  end

  task automatic cyc(); @(negedge clk); #1; endtask
  task automatic clr(); wr_en = 0; tick = 0; fcr_wr = 0; sts_wr = 0; endtask
  task automatic put(input logic [7:0] b); wr_en = 1; wr_data = b; cyc(); clr(); endtask
  task automatic pop1(); tick = 1; cyc(); clr(); endtask
  task automatic sts(input bit te, input bit td); sts_wr = 1; sts_tend = te; sts_tdfe = td; cyc(); clr(); endtask
  task automatic fcr(input logic [7:0] v); fcr_wr = 1; fcr_data = v; cyc(); clr(); endtask

  initial begin
    #1_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    cyc();
    phase = "R1";
    chk("R1 tend", tend, 1); chk("R1 tdfe", tdfe, 1); chk("R1 txi", txi, 0);
    chk("R1 count", cnt_reg, 16'h0000);

    phase = "R11"; tie = 1;
    for (int i = 0; i < 5; i++) put(8'hA0 + 8'(i));
    chk("R11 tend", tend, 1); chk("R11 txi", txi, 0); chk("R11 count", cnt_reg[12:8], 5);

    phase = "R9";
    sts(0, 0);
    chk("R9 tend cleared", tend, 0); chk("R9 tdfe held", tdfe, 1);

    phase = "R2";
    pop1();
    chk("R2 valid", tx_valid, 1); chk("R2 data", tx_data, 8'hA0);
    chk("R6 dma", dma, 1); chk("R6 txi", txi, 1);
    cyc();
    chk("R6 dma one cycle", dma, 0);
    phase = "R10";
    sts(1, 0);
    chk("R10 txi kept low level", txi, 1);
    phase = "R7";
    for (int i = 0; i < 4; i++) begin pop1(); cyc(); end
    chk("R7 tend", tend, 1); chk("R7 count", cnt_reg[12:8], 0);
    phase = "R2";
    pop1();
    chk("R2 empty tick", tx_valid, 0);

    phase = "R3";
    for (int i = 0; i < 20; i++) put(8'hB0 + 8'(i));
    chk("R3 full count", cnt_reg[12:8], 16);
    wr_en = 1; wr_data = 8'hEE; tick = 1; cyc(); clr();
    chk("R3 drop on full", cnt_reg[12:8], 15); chk("R2 order", tx_data, 8'hB0);
    chk("R6 no dma above trig", dma, 0);

    phase = "R10";
    sts(0, 0);
    chk("R10 tdfe cleared", tdfe, 0); chk("R10 txi withdrawn", txi, 0); chk("R9 tend", tend, 0);

    phase = "R5";
    fcr(8'h30);
    for (int i = 0; i < 13; i++) pop1();
    chk("R5 count", cnt_reg[12:8], 2); chk("R5 tdfe above trig1", tdfe, 0);
    pop1();
    chk("R5 tdfe at trig1", tdfe, 1); chk("R6 dma", dma, 1); chk("R6 txi", txi, 1); chk("R7 tend not yet", tend, 0);
    pop1();
    chk("R7 tend empty", tend, 1);
    fcr(8'h10);
    for (int i = 0; i < 6; i++) put(8'hC0 + 8'(i));
    sts(1, 0);
    chk("R5 tdfe clear above trig4", tdfe, 0); chk("R10 txi", txi, 0);
    pop1();
    chk("R5 tdfe at 5", tdfe, 0);
    pop1();
    chk("R5 tdfe at 4", tdfe, 1);
    fcr(8'h20);
    for (int i = 0; i < 4; i++) pop1();

    phase = "R8";
    fcr(8'h00);
    for (int i = 0; i < 3; i++) put(8'hD0 + 8'(i));
    sts(0, 1);
    wr_en = 1; wr_data = 8'h55; tick = 1; fcr_wr = 1; fcr_data = 8'h04; cyc(); clr();
    chk("R8 count", cnt_reg[12:8], 0); chk("R8 tend", tend, 1); chk("R8 tdfe", tdfe, 1);
    chk("R8 dma", dma, 1); chk("R8 no output", tx_valid, 0);
    tie = 0;
    for (int i = 0; i < 10; i++) put(8'hE0 + 8'(i));
    sts(1, 0);
    chk("R9 tdfe cleared", tdfe, 0);
    fcr(8'h04);
    chk("R8 no dma when disabled", dma, 0); chk("R8 tdfe", tdfe, 1);

    phase = "R4";
    rx_cnt = 4'hA; cyc();
    chk("R4 word", cnt_reg, 16'h000A);
    put(8'h11); put(8'h22);
    chk("R4 word filled", cnt_reg, 16'h020A);

    cyc();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule